// File: doc/BRIEF.md
# Address Step Unit

This block forms the address that a processor core places on its external address pins. A 16-bit latch captures a value from the shared internal bidirectional bus. A combinational step path then adds +1, subtracts 1 or passes the latched value through unchanged. A narrow mode limits the counting to the low 6 bits, which is how the memory refresh counter is advanced. A clear input forces the step result to zero, so the program counter or the refresh counter can be reset through the same path.

A registered pin mux picks the value for the address pins: the step result or the raw latch contents. When neither source is selected, the pins keep their value. The step result can also be driven back onto the internal bus through a tri-state enable, so a stepped pointer can be written back to the register file. A flag goes high whenever the address pins read 0x0001.

Latency: a value that the latch captures on clock edge k appears on `addr_o` after edge k+1. The write-back onto the bus and the flag are combinational from the latch and from `addr_o` respectively.

Top module: `addr_step_unit`

## Requirements
- R1: When `latch_we_i` is 1 at a rising clock edge, the latch captures `ibus_io`. When it is 0, the latch keeps its value whatever the bus carries.
- R2: With `step_en_i`=1 and `dir_dn_i`=0, the step result is the latch value plus 1.
- R3: With `step_en_i`=1 and `dir_dn_i`=1, the step result is the latch value minus 1.
- R4: With `step_en_i`=0, the step result equals the latch value for either direction.
- R5: Full-width stepping wraps modulo 2^16: 0xFFFF plus 1 gives 0x0000, and 0x0000 minus 1 gives 0xFFFF.
- R6: With `lim6_i`=1, only bits 5..0 step, wrapping modulo 64 (0x3F+1 gives 0x00 and 0x00-1 gives 0x3F in those bits), and bits 15..6 equal the latch value.
- R7: With `clr_i`=1, the step result is 0x0000 whatever the other step controls are.
- R8: When `sel_step_i`=1 at a rising edge, `addr_o` takes the step result of the latch value held before that edge.
- R9: When `sel_latch_i`=1 and `sel_step_i`=0 at a rising edge, `addr_o` takes the latch value. When both selects are 1, the step result wins.
- R10: When both selects are 0 at a rising edge, `addr_o` keeps its value.
- R11: With `wb_oe_i`=1 the block drives the step result onto `ibus_io`. With `wb_oe_i`=0 it leaves the bus undriven, so another driver's value is seen unchanged.
- R12: `addr_is_one_o` is 1 exactly when `addr_o` equals 0x0001.
- R13: While `rst_ni` is 0, the latch and `addr_o` are 0x0000 and `addr_is_one_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ibus_io | inout | 16 | Shared internal bus: latch source and write-back target |
| latch_we_i | input | 1 | Latch write enable |
| step_en_i | input | 1 | Step size: 1 means ±1, 0 means pass-through |
| dir_dn_i | input | 1 | Direction: 1 decrements, 0 increments |
| lim6_i | input | 1 | Restrict stepping to bits 5..0 |
| clr_i | input | 1 | Force the step result to zero |
| sel_step_i | input | 1 | Route the step result to the address pins (priority) |
| sel_latch_i | input | 1 | Route the latch value to the address pins |
| wb_oe_i | input | 1 | Drive the step result onto the internal bus |
| addr_o | output | 16 | Registered address pin value |
| addr_is_one_o | output | 1 | High when addr_o equals 0x0001 |

## Verification
A corrupted latch shows on the ports in two ways. On the bus it is visible in the same cycle once write-back is enabled. On `addr_o` it appears one edge after a select. Every sweep case therefore reads both paths after exactly one select edge. A fault in the carry chain shows up only at the wrap boundaries (0xFFFF, 0x0000, 0x003F, 0x0040 and their neighbours). The stepping sweep crosses those boundaries under every combination of direction, step, limit and clear. A broken hold or priority in the pin mux shows on the edge right after the selects change, and directed checks sample there.

// File: rtl/addr_unit_pkg.sv
package addr_unit_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_STEP  = 2'd1,
    SRC_LATCH = 2'd2
  } pin_src_e;
endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
  parameter int W     = 16,
  parameter int LIM_W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic         step_en_i,
  input  logic         dir_dn_i,
  input  logic         lim_i,
  input  logic         clr_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] delta;
  logic [W-1:0] full_sum;
  logic [W-1:0] lim_sum;

  // -1 is all ones; the adder wrap gives modulo behaviour for free
  assign delta    = step_en_i ? (dir_dn_i ? '1 : W'(1)) : '0;
  assign full_sum = a_i + delta;

  generate
    if (LIM_W < W) begin : g_split
      logic [LIM_W-1:0] low_sum;
      assign low_sum = a_i[LIM_W-1:0] + delta[LIM_W-1:0];
      assign lim_sum = {a_i[W-1:LIM_W], low_sum};
    end else begin : g_whole
      assign lim_sum = full_sum;
    end
  endgenerate

  always_comb begin
    if (clr_i)      y_o = '0;
    else if (lim_i) y_o = lim_sum;
    else            y_o = full_sum;
  end
endmodule

// File: rtl/addr_pin_mux.sv
module addr_pin_mux
  import addr_unit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_step_i,
  input  logic         sel_latch_i,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] latch_i,
  output logic [W-1:0] pin_o
);
  pin_src_e src;

  always_comb begin
    if (sel_step_i)       src = SRC_STEP;
    else if (sel_latch_i) src = SRC_LATCH;
    else                  src = SRC_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= '0;
    else begin
      case (src)
        SRC_STEP:  pin_o <= step_i;
        SRC_LATCH: pin_o <= latch_i;
        default:   pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit #(
  parameter int W     = 16,
  parameter int LIM_W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  inout  wire [W-1:0]  ibus_io,
  input  logic         latch_we_i,
  input  logic         step_en_i,
  input  logic         dir_dn_i,
  input  logic         lim6_i,
  input  logic         clr_i,
  input  logic         sel_step_i,
  input  logic         sel_latch_i,
  input  logic         wb_oe_i,
  output logic [W-1:0] addr_o,
  output logic         addr_is_one_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] lat_q;
  logic [W-1:0] step_y;

  addr_latch #(.W(W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (latch_we_i),
    .d_i    (ibus_io),
    .q_o    (lat_q)
  );

  addr_stepper #(.W(W), .LIM_W(LIM_W)) u_step (
    .a_i       (lat_q),
    .step_en_i (step_en_i),
    .dir_dn_i  (dir_dn_i),
    .lim_i     (lim6_i),
    .clr_i     (clr_i),
    .y_o       (step_y)
  );

  addr_pin_mux #(.W(W)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_step_i  (sel_step_i),
    .sel_latch_i (sel_latch_i),
    .step_i      (step_y),
    .latch_i     (lat_q),
    .pin_o       (addr_o)
  );

  assign ibus_io       = wb_oe_i ? step_y : 'z;
  assign addr_is_one_o = (addr_o == ONE);
endmodule

// File: rtl/addr_step_unit_chk.sv
module addr_step_unit_chk #(
  parameter int W     = 16,
  parameter int LIM_W = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         latch_we_i,
  input logic [W-1:0] ibus_io,
  input logic         clr_i,
  input logic         lim6_i,
  input logic         sel_step_i,
  input logic         sel_latch_i,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] addr_o,
  input logic         addr_is_one_o
);
  // R1
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> lat_q == $past(ibus_io));
  // R1
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(lat_q));
  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_step_i && clr_i) |=> addr_o == '0);
  // R6
  lim_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_step_i && lim6_i && !clr_i) |=> addr_o[W-1:LIM_W] == $past(lat_q[W-1:LIM_W]));
  // R9
  latch_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_latch_i && !sel_step_i) |=> addr_o == $past(lat_q));
  // R10
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_latch_i && !sel_step_i) |=> $stable(addr_o));
  // R12
  flag_low_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_is_one_o |-> addr_o[0]);
endmodule

bind addr_step_unit addr_step_unit_chk #(.W(W), .LIM_W(LIM_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .latch_we_i    (latch_we_i),
  .ibus_io       (ibus_io),
  .clr_i         (clr_i),
  .lim6_i        (lim6_i),
  .sel_step_i    (sel_step_i),
  .sel_latch_i   (sel_latch_i),
  .lat_q         (lat_q),
  .addr_o        (addr_o),
  .addr_is_one_o (addr_is_one_o)
);

// File: tb/addr_step_unit_bench.sv
module addr_step_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         drv_en;
  logic [W-1:0] drv_val;
  wire  [W-1:0] bus;
  logic         we, step, dn, lim, clr, s_step, s_lat, oe;
  logic [W-1:0] addr;
  logic         is_one;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  assign bus = drv_en ? drv_val : 'z;

  addr_step_unit u_addr_step_unit (
    .clk_i(clk), .rst_ni(rst_n), .ibus_io(bus), .latch_we_i(we),
    .step_en_i(step), .dir_dn_i(dn), .lim6_i(lim), .clr_i(clr),
    .sel_step_i(s_step), .sel_latch_i(s_lat), .wb_oe_i(oe),
    .addr_o(addr), .addr_is_one_o(is_one)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] v, bit st, bit d, bit l, bit c);
    int s;
    int r;
    s = st ? (d ? -1 : 1) : 0;
    if (c) return '0;
    if (l) begin
      r = ((int'(v[5:0]) + s) % 64 + 64) % 64;
      return {v[W-1:6], 6'(r)};
    end
    r = ((int'(v) + s) % 65536 + 65536) % 65536;
    return W'(r);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // load v into the latch with write-back off
  task automatic load(logic [W-1:0] v);
    @(negedge clk);
    drv_en = 1; drv_val = v; we = 1; oe = 0; s_step = 0; s_lat = 0;
    @(negedge clk);
    we = 0; drv_en = 0;
  endtask

  task automatic step_case(logic [W-1:0] v, bit st, bit d, bit l, bit c, string req);
    logic [W-1:0] e;
    load(v);
    step = st; dn = d; lim = l; clr = c; s_step = 1; oe = 1;
    e = model(v, st, d, l, c);
    #1;
    chk({req, " bus"}, bus, e);                   // R11
    @(negedge clk);
    chk({req, " addr"}, addr, e);                 // R8
    chk("R12", {15'd0, is_one}, {15'd0, e == 16'h0001});
    s_step = 0; oe = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; drv_en = 0; drv_val = '0; we = 0; step = 0; dn = 0;
    lim = 0; clr = 0; s_step = 0; s_lat = 0; oe = 0;
    repeat (3) @(negedge clk);
    // R13
    chk("R13 addr", addr, 16'h0000);
    chk("R13 flag", {15'd0, is_one}, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    s_lat = 1;
    @(negedge clk);
    chk("R13 latch", addr, 16'h0000);
    s_lat = 0;

    // directed corners
    step_case(16'h1234, 1, 0, 0, 0, "R2");
    step_case(16'h1234, 1, 1, 0, 0, "R3");
    step_case(16'h1234, 0, 1, 0, 0, "R4");
    step_case(16'hFFFF, 1, 0, 0, 0, "R5");
    step_case(16'h0000, 1, 1, 0, 0, "R5");
    step_case(16'h123F, 1, 0, 1, 0, "R6");
    step_case(16'hFFC0, 1, 1, 1, 0, "R6");
    step_case(16'hABCD, 1, 0, 1, 1, "R7");
    step_case(16'h0000, 1, 0, 0, 0, "R12");

    // sweep over boundary and spread values and all control combinations
    for (int i = 0; i < 48; i++) begin
      logic [W-1:0] v;
      case (i)
        0: v = 16'h0000;  1: v = 16'h0001;  2: v = 16'h0002;  3: v = 16'h003F;
        4: v = 16'h0040;  5: v = 16'h7FFF;  6: v = 16'h8000;  7: v = 16'hFFFF;
        8: v = 16'hFFFE;  9: v = 16'hFFC0; 10: v = 16'hFFBF; 11: v = 16'h0041;
        default: v = W'(i * 16'h1357 + 16'h00C3);
      endcase
      for (int m = 0; m < 16; m++)
        step_case(v, m[0], m[1], m[2], m[3], "R2/R3 sweep");
    end

    // R9: latch route and priority
    load(16'h5A3C);
    step = 1; dn = 0; lim = 0; clr = 0; s_lat = 1;
    @(negedge clk);
    chk("R9 latch", addr, 16'h5A3C);
    s_step = 1;
    @(negedge clk);
    chk("R9 priority", addr, 16'h5A3D);
    s_step = 0; s_lat = 0;

    // R10: hold with changing latch
    load(16'h0F0F);
    @(negedge clk);
    chk("R10 hold", addr, 16'h5A3D);

    // R1: latch ignores bus when we=0
    @(negedge clk);
    drv_en = 1; drv_val = 16'hDEAD; we = 0;
    #1;
    chk("R11 undriven", bus, 16'hDEAD);
    @(negedge clk);
    drv_en = 0; s_lat = 1;
    @(negedge clk);
    chk("R1 hold", addr, 16'h0F0F);
    s_lat = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule